// File: doc/BRIEF.md
# Sender-Strobed Neighbour Link Queue

This block sits on the receiving side of one data channel between two adjacent cells of a linear processor array. The upstream cell decides when a word enters the queue: it raises a tag strobe together with the word, and that strobe alone commits the write. The local cell's program never takes part in accepting data. It removes words only when it chooses to, by raising a dequeue request, and picks up the word from a registered output on the following cycle.

Neither side is ever stalled. The upstream link carries a valid-like tag and no ready, and the reader's request has no acknowledge. Flow is expected to be scheduled ahead of time. Back-pressure rules are therefore simple: the sender must never rely on the receiver to hold it off, and a word sent into a full queue is lost. To let software poll before an I/O action and to catch scheduling mistakes, the queue exposes its empty and full state and keeps two sticky error flags. One records a word dropped on a full queue and the other records a dequeue attempted on an empty queue. A dedicated clear input resets both flags.

Top module: `strobed_link_fifo`

## Requirements
- R1: While reset is asserted and on the first cycle after it, the queue reports empty=1 and full=0, both error flags read 0, and the read data output is 0.
- R2: A word is stored only in a cycle where `up_tag` is 1. Stored words leave in the order they arrived, and cycles without a tag change neither contents nor order.
- R3: `q_full` is 1 exactly when DEPTH words (default 128) are held. `q_empty` is 1 exactly when no word is held. Both flags reflect the state after the most recent clock edge.
- R4: A tagged word that arrives while the queue is full and no dequeue is requested is discarded. The stored contents stay unchanged and `err_overflow` becomes 1 and stays 1.
- R5: When the queue is full and a tagged write and a dequeue request arrive in the same cycle, both take effect. The queue stays full and no overflow is flagged.
- R6: A dequeue request while the queue is empty leaves `rd_word` at its previous value and sets `err_underflow`, which stays 1.
- R7: After a dequeue request on a non-empty queue, `rd_word` shows the oldest word from the next clock edge onward. It holds that value until the next accepted dequeue.
- R8: With `err_clear` high, both error flags read 0 after the next edge. An error event in that same cycle wins, so its flag reads 1.
- R9: A tagged write together with a dequeue request on an empty queue stores the word and flags underflow. `rd_word` is left unchanged and the queue then holds one word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| up_tag | input | 1 | Sender strobe; commits `up_word` into the queue |
| up_word | input | WIDTH | Word from the upstream cell |
| deq_req | input | 1 | Local dequeue request |
| rd_word | output | WIDTH | Registered oldest word, valid the cycle after a dequeue |
| q_empty | output | 1 | No word held |
| q_full | output | 1 | DEPTH words held |
| err_clear | input | 1 | Clears both sticky error flags |
| err_overflow | output | 1 | Sticky: a tagged word was dropped on a full queue |
| err_underflow | output | 1 | Sticky: a dequeue was requested on an empty queue |

## Verification
The bench fills the queue to the last slot and then sends one more tagged word. A design that wraps its write pointer there would overwrite the oldest word, and one whose full test is off by one would lose a slot or flag overflow one word early. It also sends a write and a dequeue together on a full queue and on an empty queue. A design that checks full before crediting the read would wrongly drop the word, and one that lets the empty read through would change `rd_word` or corrupt the count. Clears are raised both alone and together with a fresh error, so a design that gives clear priority would lose an error. Long stretches of mixed traffic that wrap both pointers many times check ordering against a queue model on every cycle.

// File: rtl/lq_pkg.sv
package lq_pkg;
  localparam int unsigned LQ_DEF_DEPTH = 128;
  localparam int unsigned LQ_DEF_WIDTH = 32;

  typedef struct packed {
    logic ovf;
    logic unf;
  } lq_err_t;
endpackage

// File: rtl/lq_ctrl.sv
module lq_ctrl
  import lq_pkg::*;
#(
  parameter int unsigned DEPTH = LQ_DEF_DEPTH
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       up_tag,
  input  logic                       deq_req,
  input  logic                       err_clear,
  output logic                       wr_en,
  output logic                       rd_en,
  output logic [$clog2(DEPTH)-1:0]   wr_addr,
  output logic [$clog2(DEPTH)-1:0]   rd_addr,
  output logic                       q_empty,
  output logic                       q_full,
  output lq_err_t                    err
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam bit          POW2 = ((DEPTH & (DEPTH - 1)) == 0);

  logic [AW-1:0] wp_q, rp_q, wp_nx, rp_nx;
  logic [CW-1:0] cnt_q;
  lq_err_t       err_q;

  assign q_empty = (cnt_q == '0);
  assign q_full  = (cnt_q == CW'(DEPTH));

  // a read is taken only when a word exists; a write also fits when the
  // same cycle frees a slot
  assign rd_en = deq_req && !q_empty;
  assign wr_en = up_tag && (!q_full || rd_en);

  generate
    if (POW2) begin : g_wrap_free
      assign wp_nx = wp_q + AW'(1);
      assign rp_nx = rp_q + AW'(1);
    end else begin : g_wrap_cmp
      assign wp_nx = (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + AW'(1);
      assign rp_nx = (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + AW'(1);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (wr_en) wp_q <= wp_nx;
      if (rd_en) rp_q <= rp_nx;
      if (wr_en && !rd_en)      cnt_q <= cnt_q + CW'(1);
      else if (rd_en && !wr_en) cnt_q <= cnt_q - CW'(1);
    end
  end

  // sticky error flags: a new event outranks the clear
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_q <= '0;
    end else begin
      if (up_tag && !wr_en)        err_q.ovf <= 1'b1;
      else if (err_clear)          err_q.ovf <= 1'b0;
      if (deq_req && q_empty)      err_q.unf <= 1'b1;
      else if (err_clear)          err_q.unf <= 1'b0;
    end
  end

  assign wr_addr = wp_q;
  assign rd_addr = rp_q;
  assign err     = err_q;

  // R2: idle cycles leave the occupancy alone
  a_r2_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!up_tag && !deq_req) |=> $stable(cnt_q));
  // R4: write into a full queue without a read is refused and flagged
  a_r4_drop_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (up_tag && q_full && !deq_req) |=> (err.ovf && q_full));
  // R5: write plus read on a full queue keeps it full without an error
  a_r5_full_swap: assert property (@(posedge clk) disable iff (!rst_n)
    (up_tag && deq_req && q_full && !err.ovf) |=> (q_full && !err.ovf));
  // R6: read on empty sets underflow
  a_r6_unf_set: assert property (@(posedge clk) disable iff (!rst_n)
    (deq_req && q_empty) |=> err.unf);
  // R8: a clear with no new event empties both flags
  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clear && !(up_tag && q_full && !deq_req) && !(deq_req && q_empty))
      |=> (!err.ovf && !err.unf));
  // R3: never both empty and full
  a_r3_status_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(q_empty && q_full));
endmodule

// File: rtl/lq_store.sv
module lq_store
  import lq_pkg::*;
#(
  parameter int unsigned DEPTH = LQ_DEF_DEPTH,
  parameter int unsigned WIDTH = LQ_DEF_WIDTH
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [$clog2(DEPTH)-1:0] wr_addr,
  input  logic [WIDTH-1:0]         wr_data,
  input  logic                     rd_en,
  input  logic [$clog2(DEPTH)-1:0] rd_addr,
  output logic [WIDTH-1:0]         rd_data
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [WIDTH-1:0] rd_q;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rd_q <= '0;
    else if (rd_en) rd_q <= mem[rd_addr];
  end

  assign rd_data = rd_q;

  // R6 / R7: output register moves only on an accepted read
  a_r7_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));
endmodule

// File: rtl/strobed_link_fifo.sv
module strobed_link_fifo
  import lq_pkg::*;
#(
  parameter int unsigned DEPTH = LQ_DEF_DEPTH,
  parameter int unsigned WIDTH = LQ_DEF_WIDTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             up_tag,
  input  logic [WIDTH-1:0] up_word,
  input  logic             deq_req,
  output logic [WIDTH-1:0] rd_word,
  output logic             q_empty,
  output logic             q_full,
  input  logic             err_clear,
  output logic             err_overflow,
  output logic             err_underflow
);
  localparam int unsigned AW = $clog2(DEPTH);

  logic          wr_en, rd_en;
  logic [AW-1:0] wr_addr, rd_addr;
  lq_err_t       err;

  lq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .up_tag    (up_tag),
    .deq_req   (deq_req),
    .err_clear (err_clear),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .wr_addr   (wr_addr),
    .rd_addr   (rd_addr),
    .q_empty   (q_empty),
    .q_full    (q_full),
    .err       (err)
  );

  lq_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (up_word),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .rd_data (rd_word)
  );

  assign err_overflow  = err.ovf;
  assign err_underflow = err.unf;

  // R9: simultaneous write and read on empty leaves exactly one word
  a_r9_empty_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (up_tag && deq_req && q_empty) |=> (!q_empty && err_underflow && $stable(rd_word)));
endmodule

// File: tb/tb_strobed_link_fifo.sv
module tb_strobed_link_fifo;
  localparam int DEPTH = 128;
  localparam int WIDTH = 32;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             up_tag, deq_req, err_clear;
  logic [WIDTH-1:0] up_word;
  logic [WIDTH-1:0] rd_word;
  logic             q_empty, q_full, err_overflow, err_underflow;

  always #10 clk = ~clk;

  strobed_link_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) dut (
    .clk(clk), .rst_n(rst_n), .up_tag(up_tag), .up_word(up_word),
    .deq_req(deq_req), .rd_word(rd_word), .q_empty(q_empty), .q_full(q_full),
    .err_clear(err_clear), .err_overflow(err_overflow), .err_underflow(err_underflow)
  );

  int unsigned      n_run = 0, n_fail = 0;
  bit               done = 1'b0;
  logic [WIDTH-1:0] mq[$];
  logic [WIDTH-1:0] m_rd = '0;
  logic             m_ovf = 1'b0, m_unf = 1'b0;
  logic [15:0]      lfsr = 16'hACE1;
  logic [WIDTH-1:0] seq = 32'h1000_0000;

  task automatic compare(string req);
    logic e_empty, e_full;
    e_empty = (mq.size() == 0);
    e_full  = (mq.size() == DEPTH);
    n_run++;
    if (q_empty !== e_empty || q_full !== e_full || rd_word !== m_rd ||
        err_overflow !== m_ovf || err_underflow !== m_unf) begin
      n_fail++;
      $display("FAIL %s: got empty=%b full=%b rd=%h ovf=%b unf=%b, expected empty=%b full=%b rd=%h ovf=%b unf=%b",
               req, q_empty, q_full, rd_word, err_overflow, err_underflow,
               e_empty, e_full, m_rd, m_ovf, m_unf);
    end
  endtask

  // called at a falling edge: drive, model the next edge, then compare
  task automatic step(input bit wr, input bit rd, input bit clr, input string req);
    int  cnt;
    bit  do_rd, do_wr;
    logic [WIDTH-1:0] w;
    w = seq;
    seq = seq + 32'h0001_0003;
    up_tag = wr; deq_req = rd; err_clear = clr; up_word = w;
    cnt   = mq.size();
    do_rd = rd && (cnt > 0);
    do_wr = wr && ((cnt < DEPTH) || do_rd);
    if (do_rd) m_rd = mq.pop_front();
    if (do_wr) mq.push_back(w);
    if (wr && !do_wr)  m_ovf = 1'b1; else if (clr) m_ovf = 1'b0;
    if (rd && cnt == 0) m_unf = 1'b1; else if (clr) m_unf = 1'b0;
    @(posedge clk);
    @(negedge clk);
    up_tag = 1'b0; deq_req = 1'b0; err_clear = 1'b0;
    compare(req);
  endtask

  function automatic logic [15:0] lfsr_next(logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete (all R), got hung, expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; up_tag = 1'b1; deq_req = 1'b0; err_clear = 1'b0; up_word = '1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare("R1 in reset");
    up_tag = 1'b0;
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    compare("R1 after reset");

    // R2, R7: a few words in, idle gaps, then out in order
    for (int i = 0; i < 5; i++) begin
      step(1, 0, 0, "R2 write");
      step(0, 0, 0, "R2 idle");
    end
    for (int i = 0; i < 5; i++) step(0, 1, 0, "R7 read order");

    // R6: read on empty holds data and sets underflow
    step(0, 1, 0, "R6 read empty");
    step(0, 0, 0, "R6 sticky");
    step(0, 0, 1, "R8 clear");

    // R3: fill to the last slot
    for (int i = 0; i < DEPTH; i++) step(1, 0, 0, "R3 fill");
    // R4: extra word is dropped
    step(1, 0, 0, "R4 write full");
    step(0, 0, 0, "R4 sticky");
    // R5: write and read together on full
    step(1, 1, 0, "R5 full swap");
    step(1, 1, 0, "R5 full swap again");
    // R8: clear together with a new overflow keeps the flag
    step(1, 0, 1, "R8 clear vs new error");
    step(0, 0, 1, "R8 clear");
    // drain everything, confirming the dropped words never appear
    for (int i = 0; i < DEPTH; i++) step(0, 1, 0, "R4 drain order");
    step(0, 0, 1, "R8 clear");

    // R9: write and read together on empty
    step(1, 1, 0, "R9 empty pair");
    step(0, 1, 0, "R9 word present");
    step(0, 0, 1, "R8 clear");

    // mixed traffic, alternating fill-biased and drain-biased phases
    for (int ph = 0; ph < 40; ph++) begin
      for (int i = 0; i < 300; i++) begin
        bit wr, rd, clr;
        lfsr = lfsr_next(lfsr);
        if (ph[0]) begin
          wr = lfsr[0] | lfsr[1];
          rd = lfsr[2] & lfsr[3];
        end else begin
          wr = lfsr[0] & lfsr[4];
          rd = lfsr[2] | lfsr[3];
        end
        clr = (lfsr[15:11] == 5'd0);
        step(wr, rd, clr, "R2 mixed traffic");
      end
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule